// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Bus Controller

This block lets synchronous logic use a byte-wide pseudo-static RAM. The memory has 512K locations and asynchronous control pins. A user request carries a write flag, a 19-bit address and a data byte, and it uses a valid/ready handshake. The controller accepts a request only when `req_valid` and `req_ready` are both high on a rising clock edge. `req_ready` stays low for the whole memory cycle, so a requester that keeps `req_valid` high simply waits: nothing is queued. Each accepted transaction ends with a one-cycle `rsp_valid` pulse, and for a read that pulse comes with the byte on `rsp_rdata`. The response has no back-pressure. The requester must take it in the cycle it is shown.

On the memory side the controller drives two select pins (one active low, one active high), an active-low output enable, an active-low write enable and the address bus. The data bus is split into an output byte, a pad drive enable and an input byte. The pad itself lives outside the block.

Every interval is a parameter counted in clock cycles. An integrator sets each one to the ceiling of the nanosecond minimum divided by the clock period, so the same RTL covers the 55, 60 and 70 ns grades. The sequence of a transaction is:
1. Setup: the address is driven while the selects are still inactive. This makes reads select-controlled.
2. Access: the selects and the strobe are active for a counted number of cycles.
3. Hold: the write enable rises while the selects and the data are still held.
4. Recovery: the controller waits until the full cycle time has passed.

Top module: `async_pram_ctl`

## Requirements
- R1: Reset state. While reset is held and in the cycle after it is released, the pins are as follows: `mem_sel_n`=1, `mem_sel_p`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: Request handshake. A request is taken on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle ends. While `req_ready` is 0, the request inputs have no effect on any pin.
- R3: Setup phase. For `SETUP_CYC` cycles after acceptance, `mem_addr` already carries the accepted address. During these cycles `mem_sel_n`=1, `mem_sel_p`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R4: Address stability. `mem_addr` holds the accepted address, unchanged, from the first setup cycle until the controller is idle again.
- R5: Write access. For exactly `ACCESS_CYC` cycles the pins are `mem_sel_n`=0, `mem_sel_p`=1, `mem_we_n`=0 and `mem_oe_n`=1, with `mem_dq_oe`=1 and `mem_dq_out` equal to the write byte. `mem_we_n` is never 0 unless both selects are active.
- R6: Write end. `mem_we_n` returns to 1 while both selects are still active and `mem_dq_oe` is still 1 with the same byte. These stay in that state for `HOLD_CYC` cycles. After that, `mem_dq_oe` is 0 and the selects are inactive.
- R7: Read access. For `ACCESS_CYC` cycles the pins are `mem_sel_n`=0, `mem_sel_p`=1, `mem_oe_n`=0 and `mem_we_n`=1, and `mem_dq_oe` stays 0 for the whole read.
- R8: Response. `rsp_rdata` takes the value of `mem_dq_in` sampled at the edge that ends the last access cycle of a read. `rsp_valid` is 1 for exactly one cycle, the cycle after the last access cycle, for reads and for writes alike.
- R9: Bus safety. `mem_dq_oe` is 1 only while `mem_oe_n` is 1 and both selects are active. `mem_we_n` and `mem_oe_n` are never 0 together.
- R10: Cycle length. The controller returns to idle exactly T cycles after acceptance. T = max(`CYCLE_CYC`, `SETUP_CYC`+`ACCESS_CYC`+`HOLD_CYC`+1), so a cycle is never shorter than the cycle-time parameter.
- R11: Back-to-back requests. A request held valid through the final recovery cycle is not taken in that cycle. It is taken on the first idle cycle, so successive acceptances are T+1 edges apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel_p | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Active-low memory output enable |
| mem_we_n | output | 1 | Active-low memory write enable |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Byte for the data pads |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_in | input | 8 | Byte from the data pads |

## Verification
Two things can coincide in the last recovery cycle: a new request arrives and the sequencer returns to idle. Two things also coincide at the end of a write: the write enable rises in the same cycle that the selects and the data drive must still be held. The bench keeps `req_valid` high through every busy cycle. During those cycles it presents a decoy request: a write to the inverted address with a fixed byte. The real next request is swapped in only on the first idle cycle. A design that accepted early would show the decoy address on the pins or corrupt the stored pattern. The sweep writes a computed byte to 256 addresses and reads each one back through a memory model that stores on the rising edge of the write enable. This only works if the selects and the data are still valid at that edge.

// File: rtl/apc_pkg.sv
package apc_pkg;

  // Phase of one memory cycle. The numeric encoding is internal only.
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_ACCESS  = 3'd2,
    PH_HOLD    = 3'd3,
    PH_RECOVER = 3'd4
  } phase_e;

  // Length of one cycle: the cycle-time parameter, but never shorter
  // than the phases it has to contain.
  function automatic int total_cycles(int s, int a, int h, int c);
    int need;
    need = s + a + h + 1;
    return (c > need) ? c : need;
  endfunction

endpackage

// File: rtl/apc_cycle_timer.sv
module apc_cycle_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          busy,
  output logic [CW-1:0] elapsed
);

  // Cycles since acceptance: 0 in the first setup cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)     elapsed <= '0;
    else if (start) elapsed <= '0;
    else if (busy)  elapsed <= elapsed + 1'b1;
  end

endmodule

// File: rtl/apc_sequencer.sv
module apc_sequencer
  import apc_pkg::*;
#(
  parameter int S_CYC = 1,
  parameter int A_CYC = 7,
  parameter int H_CYC = 1,
  parameter int T_CYC = 10,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] elapsed,
  output phase_e        phase_q,
  output phase_e        phase_d,
  output logic          start,
  output logic          last_access
);

  localparam logic [CW-1:0] E_ACC  = CW'(S_CYC);
  localparam logic [CW-1:0] E_HOLD = CW'(S_CYC + A_CYC);
  localparam logic [CW-1:0] E_REC  = CW'(S_CYC + A_CYC + H_CYC);
  localparam logic [CW-1:0] E_LACC = CW'(S_CYC + A_CYC - 1);
  localparam logic [CW-1:0] E_LAST = CW'(T_CYC - 1);

  logic [CW-1:0] e_next;

  // The next phase is decoded from the elapsed count it will have.
  always_comb begin
    start  = (phase_q == PH_IDLE) && req_valid;
    e_next = start ? '0 : elapsed + 1'b1;
    if (phase_q == PH_IDLE && !start)
      phase_d = PH_IDLE;
    else if (phase_q != PH_IDLE && elapsed == E_LAST)
      phase_d = PH_IDLE;
    else if (e_next < E_ACC)
      phase_d = PH_SETUP;
    else if (e_next < E_HOLD)
      phase_d = PH_ACCESS;
    else if (e_next < E_REC)
      phase_d = PH_HOLD;
    else
      phase_d = PH_RECOVER;
  end

  assign last_access = (phase_q == PH_ACCESS) && (elapsed == E_LACC);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/apc_pin_drive.sv
module apc_pin_drive
  import apc_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          last_access,
  input  phase_e        phase_d,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_sel_n,
  output logic          mem_sel_p,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);

  logic wr_q, wr_nxt, sel_d, acc_d;

  // The memory pins are asynchronous, so every one of them comes from a
  // flop, loaded from the next phase at the edge the phase changes.
  always_comb begin
    wr_nxt = start ? req_write : wr_q;
    acc_d  = (phase_d == PH_ACCESS);
    sel_d  = acc_d || (phase_d == PH_HOLD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q       <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (start) begin
      wr_q       <= req_write;
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_sel_n <= 1'b1;
      mem_sel_p <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_sel_n <= !sel_d;
      mem_sel_p <= sel_d;
      mem_we_n  <= !(acc_d && wr_nxt);
      mem_oe_n  <= !(acc_d && !wr_nxt);
      mem_dq_oe <= sel_d && wr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= last_access;
      if (last_access && !wr_q) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/async_pram_ctl.sv
module async_pram_ctl
  import apc_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int ACCESS_CYC = 7,
  parameter int HOLD_CYC   = 1,
  parameter int CYCLE_CYC  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_sel_n,
  output logic              mem_sel_p,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int A_EFF = (ACCESS_CYC < 1) ? 1 : ACCESS_CYC;
  localparam int H_EFF = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
  localparam int T_CYC = total_cycles(SETUP_CYC, A_EFF, H_EFF, CYCLE_CYC);
  localparam int CW    = $clog2(T_CYC + 1);

  phase_e        phase_q, phase_d;
  logic          start, last_access;
  logic [CW-1:0] elapsed;

  apc_cycle_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (phase_q != PH_IDLE),
    .elapsed (elapsed)
  );

  apc_sequencer #(
    .S_CYC (SETUP_CYC),
    .A_CYC (A_EFF),
    .H_CYC (H_EFF),
    .T_CYC (T_CYC),
    .CW    (CW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .elapsed     (elapsed),
    .phase_q     (phase_q),
    .phase_d     (phase_d),
    .start       (start),
    .last_access (last_access)
  );

  apc_pin_drive #(.AW(ADDR_W), .DW(DATA_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .last_access (last_access),
    .phase_d     (phase_d),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .mem_dq_in   (mem_dq_in),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .mem_sel_n   (mem_sel_n),
    .mem_sel_p   (mem_sel_p),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe)
  );

  assign req_ready = (phase_q == PH_IDLE);

endmodule

// File: rtl/apc_checker.sv
module apc_checker #(
  parameter int AW      = 19,
  parameter int ACC_CYC = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_sel_n,
  input logic          mem_sel_p,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);

  localparam int WCW = $clog2(ACC_CYC + 2);
  logic [WCW-1:0] we_low_cnt;

  // Length of the current run of write-enable-low cycles.
  always_ff @(posedge clk) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else                we_low_cnt <= '0;
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  p_we_needs_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel_p));

  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == WCW'(ACC_CYC)));

  p_we_end_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_sel_n && mem_sel_p));

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_dq_drive_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_sel_n && mem_sel_p));

  p_we_oe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

endmodule

bind async_pram_ctl apc_checker #(.AW(ADDR_W), .ACC_CYC(A_EFF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_sel_n (mem_sel_n),
  .mem_sel_p (mem_sel_p),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/async_pram_ctl_tb_top.sv
module async_pram_ctl_tb_top;

  localparam int S   = 1;
  localparam int A   = 7;
  localparam int H   = 1;
  localparam int CYC = 7;
  localparam int TOT = (CYC > S + A + H + 1) ? CYC : S + A + H + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_sel_n, mem_sel_p, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  async_pram_ctl #(
    .SETUP_CYC(S), .ACCESS_CYC(A), .HOLD_CYC(H), .CYCLE_CYC(CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_sel_n(mem_sel_n),
    .mem_sel_p(mem_sel_p), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Memory model: 256 bytes addressed by the low address bits. It stores on
  // the rising write enable, which is valid only if the selects and the
  // data drive are still held at that edge.
  logic [7:0] marr [256];
  initial for (int i = 0; i < 256; i++) marr[i] = 8'h00;
  always @(posedge mem_we_n)
    if (!mem_sel_n && mem_sel_p && mem_dq_oe) marr[mem_addr[7:0]] = mem_dq_out;
  assign mem_dq_in = (!mem_sel_n && mem_sel_p && !mem_oe_n && mem_we_n)
                     ? marr[mem_addr[7:0]] : 8'h00;

  function automatic logic [18:0] addr_of(int i);
    return {11'(i * 37 + 5), 8'(i)};
  endfunction
  function automatic logic [7:0] data_of(int i);
    return 8'(i * 29 + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge while the controller is idle.
  // Returns at the falling edge of the first idle cycle afterwards.
  task automatic run_txn(input logic wr, input int i);
    logic [18:0] a;
    logic [4:0] exp_v, act_v;
    bit acc, hld;
    string tag;
    a = addr_of(i);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = data_of(i);
    chk(req_ready == 1'b1, "R11", "ready on first idle cycle", req_ready, 1);
    @(negedge clk);
    // Decoy while busy: must be ignored (R2), valid stays high (R11).
    req_write = 1'b1; req_addr = ~a; req_wdata = 8'hA5;
    for (int c = 0; c < TOT; c++) begin
      acc = (c >= S) && (c < S + A);
      hld = (c >= S + A) && (c < S + A + H);
      exp_v = {!(acc || hld), (acc || hld), !(acc && wr), !(acc && !wr),
               wr && (acc || hld)};
      act_v = {mem_sel_n, mem_sel_p, mem_we_n, mem_oe_n, mem_dq_oe};
      if (c < S)       tag = "R3";
      else if (acc)    tag = wr ? "R5" : "R7";
      else if (hld)    tag = wr ? "R6" : "R10";
      else             tag = "R10";
      chk(act_v == exp_v, tag, "control pins", act_v, exp_v);
      chk(mem_addr == a, "R4", "address held", mem_addr, a);
      chk(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
      chk(rsp_valid == (c == S + A), "R8", "done pulse", rsp_valid, c == S + A);
      if (wr && (acc || hld))
        chk(mem_dq_out == data_of(i), "R5", "write byte", mem_dq_out, data_of(i));
      if (!wr && c == S + A)
        chk(rsp_rdata == data_of(i), "R8", "read byte", rsp_rdata, data_of(i));
      @(negedge clk);
    end
    chk(req_ready == 1'b1, "R10", "idle after full cycle", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({mem_sel_n, mem_sel_p, mem_we_n, mem_oe_n, mem_dq_oe} == 5'b10110,
        "R1", "pins in reset", {mem_sel_n, mem_sel_p, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_sel_n, mem_sel_p, mem_we_n, mem_oe_n, mem_dq_oe} == 5'b10110,
        "R1", "pins after reset", {mem_sel_n, mem_sel_p, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ready/done after reset",
        {req_ready, rsp_valid}, 2'b10);
    for (int i = 0; i < 256; i++) run_txn(1'b1, i);
    for (int i = 0; i < 256; i++) run_txn(1'b0, i);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R2", "quiet when no request",
        {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule